// File: doc/BRIEF.md
# Keyed Lockable Watchdog Timer

This block is a watchdog timer with a simple register bus. An 8-bit up-counter advances on one of four slow tick rates. The tick rates arrive as pre-divided, single-cycle enable pulses on the bus clock. One programmable count value raises an interrupt, and a second one raises a reset request for the system reset generator.

Software keeps the system alive by writing a restart key. This clears the counter and withdraws a pending reset request. A second key locks the timer. From then on, configuration writes are dropped and the timer stays enabled until the block itself is reset. Interrupt status is handled through four registers: enable, status, clear and set. The interrupt line is the status bit gated by the enable register bit.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the configuration, count, lock state, interrupt enable and interrupt status read as zero, and `irq_o` and `rst_req_o` are low.
- R2: The configuration word at offset 0x0 holds these fields, and it reads back as written while unlocked:
  - enable at bit 0
  - interrupt arm at bit 1
  - reset arm at bit 2
  - interrupt compare at bits 15:8
  - reset compare at bits 23:16
  - rate select at bits 26:24
- R3: The counter advances by one on each pulse of the selected tick, and only while enabled. Rate select 1 uses `tick_i[0]`, 2 uses `tick_i[1]`, 3 uses `tick_i[2]` and 4 uses `tick_i[3]`. Select 0 and codes 5 to 7 stop the count. The count reads at offset 0xC.
- R4: The counter saturates at 0xFF and does not wrap.
- R5: Writing 0xB2 in bits 7:0 at offset 0x4 clears the counter on the next edge. Any other value there has no effect. Reads of offset 0x4 return zero.
- R6: Writing 0x3A in bits 7:0 at offset 0x8 locks the timer. After the lock, configuration writes are ignored and the enable bit reads as 1 while counting continues. Offset 0x8 reads the lock state in bit 0. Any other value has no effect, and only the block reset clears the lock.
- R7: The interrupt status bit is set when an increment brings the count equal to the interrupt compare, but only if the interrupt arm bit is 1.
- R8: Status reads at 0x204 bit 0. Writing 1 to bit 0 of 0x208 clears it, and writing 1 to bit 0 of 0x20C sets it. Bit 0 at 0x200 is the enable. `irq_o` equals status AND enable.
- R9: `rst_req_o` rises when an increment brings the count equal to the reset compare, but only if the reset arm bit is 1. It stays high until a valid restart or the block reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low block reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_i | input | 4 | Tick enable pulses, slowest rate at the highest bit |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request level |

## Verification
The bench builds the block with the default `ADDR_W` of 10, which is the narrowest width that decodes the interrupt registers at 0x200 to 0x20C. The bench drives the tick inputs directly instead of from real dividers. Each count step therefore costs two bus clocks, so saturation after 255 steps, every rate-select code, and both compare matches are reached within a few thousand cycles.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [3:0]        tick_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] OFS_KICK = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] OFS_LOCK = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'('h00C);
  localparam logic [ADDR_W-1:0] OFS_IEN  = ADDR_W'('h200);
  localparam logic [ADDR_W-1:0] OFS_IST  = ADDR_W'('h204);
  localparam logic [ADDR_W-1:0] OFS_ICLR = ADDR_W'('h208);
  localparam logic [ADDR_W-1:0] OFS_ISET = ADDR_W'('h20C);
  localparam logic [7:0] KICK_KEY = 8'hB2;
  localparam logic [7:0] LOCK_KEY = 8'h3A;
  localparam logic [7:0] CNT_MAX  = 8'hFF;

  logic       cfg_en, cfg_ie, cfg_re, locked;
  logic [7:0] int_cmp, rst_cmp, count;
  logic [2:0] rate_sel;
  logic       ien, ist, rst_req;
  logic       tick_hit;

  wire cfg_wr  = bus_we && bus_addr == OFS_CFG && !locked;
  wire kick    = bus_we && bus_addr == OFS_KICK && bus_wdata[7:0] == KICK_KEY;
  wire lock_wr = bus_we && bus_addr == OFS_LOCK && bus_wdata[7:0] == LOCK_KEY;
  wire run     = cfg_en | locked;
  wire step    = run && tick_hit && count != CNT_MAX;
  wire [7:0] nxt = count + 8'd1;
  wire int_hit = step && cfg_ie && nxt == int_cmp;
  wire rst_hit = step && cfg_re && nxt == rst_cmp;

  always_comb begin
    case (rate_sel)
      3'd1:    tick_hit = tick_i[0];
      3'd2:    tick_hit = tick_i[1];
      3'd3:    tick_hit = tick_i[2];
      3'd4:    tick_hit = tick_i[3];
      default: tick_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en <= 1'b0; cfg_ie <= 1'b0; cfg_re <= 1'b0;
      int_cmp <= '0; rst_cmp <= '0; rate_sel <= '0;
    end else if (cfg_wr) begin
      cfg_en   <= bus_wdata[0];
      cfg_ie   <= bus_wdata[1];
      cfg_re   <= bus_wdata[2];
      int_cmp  <= bus_wdata[15:8];
      rst_cmp  <= bus_wdata[23:16];
      rate_sel <= bus_wdata[26:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0; locked <= 1'b0; rst_req <= 1'b0; ien <= 1'b0; ist <= 1'b0;
    end else begin
      if (kick) count <= '0;
      else if (step) count <= nxt;
      if (lock_wr) locked <= 1'b1;
      if (kick) rst_req <= 1'b0;
      else if (rst_hit) rst_req <= 1'b1;
      if (bus_we && bus_addr == OFS_IEN) ien <= bus_wdata[0];
      if (int_hit || (bus_we && bus_addr == OFS_ISET && bus_wdata[0])) ist <= 1'b1;
      else if (bus_we && bus_addr == OFS_ICLR && bus_wdata[0]) ist <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CFG: bus_rdata = {5'd0, rate_sel, rst_cmp, int_cmp, 5'd0, cfg_re, cfg_ie, run};
      OFS_LOCK: bus_rdata[0] = locked;
      OFS_CNT: bus_rdata[7:0] = count;
      OFS_IEN: bus_rdata[0] = ien;
      OFS_IST: bus_rdata[0] = ist;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o     = ist & ien;
  assign rst_req_o = rst_req;

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !kick) |=> count == CNT_MAX); // R4
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !kick |=> (count == $past(count) || count == $past(count) + 8'd1)); // R3
  AST_RATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 3'd0 && !kick) |=> $stable(count)); // R3
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (count == 8'd0 && !rst_req_o)); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(int_cmp) && $stable(rst_cmp) && $stable(rate_sel) && $stable(cfg_ie))); // R6
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && !kick) |=> rst_req_o); // R9
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] tick_i = '0;
  logic irq_o, rst_req_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  keyed_watchdog #(.ADDR_W(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
    .irq_o(irq_o), .rst_req_o(rst_req_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i[k] = 1'b1;
      @(negedge clk); tick_i[k] = 1'b0;
    end
  endtask

  task automatic chk_cnt(input string req, input logic [7:0] exp);
    logic [31:0] d;
    rd(10'h00C, d); chk(req, d, {24'd0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(10'h000, d); chk("R1 cfg", d, 0);
    chk_cnt("R1 count", 8'd0);
    rd(10'h008, d); chk("R1 lock", d, 0);
    rd(10'h200, d); chk("R1 ien", d, 0);
    rd(10'h204, d); chk("R1 ist", d, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 rst_req", rst_req_o, 0);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(10'h000, 32'h0312_0507);
    rd(10'h000, d); chk("R2 readback", d, 32'h0312_0507);
    wr(10'h000, 32'h0);
    rd(10'h000, d); chk("R2 cleared", d, 0);
  endtask

  task automatic t_rates;
    logic [31:0] d;
    wr(10'h000, 32'h0100_0001);
    pulse(1, 2); chk_cnt("R3 unselected tick", 8'd0);
    pulse(0, 3); chk_cnt("R3 sel1 counts", 8'd3);
    wr(10'h000, 32'h0200_0001);
    pulse(0, 1); chk_cnt("R3 sel2 ignores tick0", 8'd3);
    pulse(1, 1); chk_cnt("R3 sel2 counts", 8'd4);
    wr(10'h000, 32'h0300_0001); pulse(2, 1); chk_cnt("R3 sel3", 8'd5);
    wr(10'h000, 32'h0400_0001); pulse(3, 1); chk_cnt("R3 sel4", 8'd6);
    wr(10'h000, 32'h0000_0001);
    for (int k = 0; k < 4; k++) pulse(k, 1);
    chk_cnt("R3 sel0 off", 8'd6);
    wr(10'h000, 32'h0500_0001);
    for (int k = 0; k < 4; k++) pulse(k, 1);
    chk_cnt("R3 sel5 off", 8'd6);
    wr(10'h000, 32'h0100_0000); pulse(0, 2); chk_cnt("R3 disabled", 8'd6);
    wr(10'h004, 32'h0000_00B3); chk_cnt("R5 wrong key", 8'd6);
    wr(10'h004, 32'h0000_00B2); chk_cnt("R5 restart", 8'd0);
    rd(10'h004, d); chk("R5 read zero", d, 0);
  endtask

  task automatic t_sat;
    wr(10'h000, 32'h0400_0001);
    pulse(3, 254); chk_cnt("R4 at 254", 8'hFE);
    pulse(3, 1); chk_cnt("R4 at max", 8'hFF);
    pulse(3, 40); chk_cnt("R4 no wrap", 8'hFF);
    wr(10'h004, 32'hB2); chk_cnt("R5 restart from max", 8'd0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(10'h000, 32'h0100_0303);
    pulse(0, 2); rd(10'h204, d); chk("R7 before match", d, 0);
    pulse(0, 1); rd(10'h204, d); chk("R7 on match", d, 1);
    chk("R8 irq masked", irq_o, 0);
    wr(10'h200, 1); chk("R8 irq enabled", irq_o, 1);
    wr(10'h208, 1); rd(10'h204, d); chk("R8 clear", d, 0);
    chk("R8 irq after clear", irq_o, 0);
    wr(10'h20C, 1); chk("R8 set", irq_o, 1);
    wr(10'h208, 1);
    wr(10'h004, 32'hB2);
    wr(10'h000, 32'h0100_0301);
    pulse(0, 4); rd(10'h204, d); chk("R7 unarmed no status", d, 0);
    chk("R8 irq stays low", irq_o, 0);
    wr(10'h200, 0);
  endtask

  task automatic t_rst;
    wr(10'h004, 32'hB2);
    wr(10'h000, 32'h0102_0005);
    pulse(0, 1); chk("R9 before match", rst_req_o, 0);
    pulse(0, 1); chk("R9 on match", rst_req_o, 1);
    pulse(0, 3); chk("R9 held", rst_req_o, 1);
    wr(10'h004, 32'hB2); chk("R9 restart drops", rst_req_o, 0);
    wr(10'h000, 32'h0102_0001);
    pulse(0, 3); chk("R9 unarmed", rst_req_o, 0);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    wr(10'h004, 32'hB2);
    wr(10'h000, 32'h0100_0000);
    wr(10'h008, 32'h3B); rd(10'h008, d); chk("R6 wrong key", d, 0);
    wr(10'h000, 32'h0100_0000);
    rd(10'h000, d); chk("R6 unlocked cfg", d, 32'h0100_0000);
    wr(10'h008, 32'h3A); rd(10'h008, d); chk("R6 locked", d, 1);
    rd(10'h000, d); chk("R6 enable forced", d, 32'h0100_0001);
    pulse(0, 1); chk_cnt("R6 counts when locked", 8'd1);
    wr(10'h000, 32'h0000_0000);
    rd(10'h000, d); chk("R6 cfg frozen", d, 32'h0100_0001);
    pulse(0, 1); chk_cnt("R6 still counting", 8'd2);
    wr(10'h008, 32'h0); rd(10'h008, d); chk("R6 sticky", d, 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_rates();
    t_sat();
    t_irq();
    t_rst();
    t_lock();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule